// File: doc/BRIEF.md
# Three-Area Banked Address Translator

This block maps the 16-bit logical addresses issued by a small 8-bit processor onto a 20-bit physical memory bus. It can therefore reach 1 MiB of memory through a 64 KiB window. The logical space stays contiguous. A single boundary register cuts it at 4 KiB granularity into up to three regions: a low fixed region, a relocatable bank window and a relocatable high region.

The low region always maps one-to-one. For each of the other two regions, an 8-bit base is added to logical bits 15:12 to form physical bits 19:12. Logical bits 11:0 pass straight through to the physical address.

Software sets the mapping with writes through a small I/O-port interface. It can read back every register through the same interface. The translation itself is purely combinational, so each memory access sees the register contents stored at that moment. After reset the mapping is the identity, so code written for a flat 64 KiB machine runs unchanged.

Top module: `bank_xlate_top`

## Requirements
- R1: After reset the boundary register (select code 0) reads 0xF0, and the window base (select code 1) and high base (select code 2) both read 0x00. Logical 0x1000 then maps to 0x01000 and logical 0xF800 maps to 0x0F800.
- R2: A write with `io_wr` high stores `io_wdata` into the register chosen by `io_sel` at the next rising clock edge. `io_rdata` always returns the stored value of the selected register. Translation in the cycle of a write still uses the value held before that edge.
- R3: Let page = logical[15:12], win_start = boundary[3:0] and high_start = boundary[7:4]. If page ≥ high_start, the access is in the high region (`area` = 2). Otherwise, if page ≥ win_start, it is in the window region (`area` = 1). Otherwise it is in the low region (`area` = 0).
- R4: In the low region, the physical address is the logical address zero-extended to 20 bits.
- R5: In the window region, physical[19:12] = (page + window base) mod 256.
- R6: In the high region, physical[19:12] = (page + high base) mod 256.
- R7: Physical bits 11:0 always equal logical bits 11:0.
- R8: When win_start is 0, the low region is empty. When high_start ≤ win_start, the window region is empty. With boundary 0xC4, the window spans 0x4000–0xBFFF and the high region starts at 0xC000.
- R9: Select code 3 addresses no register. A write to it changes no register, and a read of it returns 0x00.
- R10: The base addition wraps modulo 256 with no fault. With window base 0x0A, logical 0x4000 maps to 0x0E000. With base 0x08 it maps to 0x0C000. With base 0xFF it maps to 0x03000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 2 | Register select: 0 boundary, 1 window base, 2 high base, 3 unused |
| io_wr | input | 1 | Write strobe, sampled at the rising edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data of the selected register (combinational) |
| log_addr | input | 16 | Logical address of the current access |
| phys_addr | output | 20 | Translated physical address (combinational) |
| area | output | 2 | Region of the access: 0 low, 1 window, 2 high |

## Verification
`phys_addr`, `area` and `io_rdata` are due in the same cycle as the address or select that produces them, with zero edges of latency. A register write is due exactly one rising edge later.

The bench drives each new input on the falling edge. It compares all three outputs 1 ns later against a behavioural model that holds the register contents from before the coming edge. Only after that rising edge does it commit the write into the model. This means a check never sees a write early, and it catches one that lands late.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    AREA_LOW  = 2'd0,
    AREA_WIN  = 2'd1,
    AREA_HIGH = 2'd2
  } area_e;

  localparam int NUM_REGS = 3;
  localparam int SEL_W    = 2;

  localparam logic [SEL_W-1:0] SEL_BOUND = 2'd0;
  localparam logic [SEL_W-1:0] SEL_WBASE = 2'd1;
  localparam logic [SEL_W-1:0] SEL_HBASE = 2'd2;

endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
  import xlate_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  BOUND_RST = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  io_sel,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] bound_q,
  output logic [DATA_W-1:0] wbase_q,
  output logic [DATA_W-1:0] hbase_q
);

  localparam int SEL_SPAN = 1 << SEL_W;

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              sel_valid;
  logic              write_lost;

  function automatic logic [DATA_W-1:0] reset_value(input int idx);
    if (idx == int'(SEL_BOUND)) return DATA_W'(BOUND_RST);
    return '0;
  endfunction

  assign sel_valid  = (int'(io_sel) < NUM_REGS);
  assign write_lost = io_wr && !sel_valid;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[gi] <= reset_value(gi);
      else if (io_wr && (io_sel == SEL_W'(gi)))
        regs_q[gi] <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (io_sel == SEL_W'(k)) io_rdata = regs_q[k];
  end

  assign bound_q = regs_q[SEL_BOUND];
  assign wbase_q = regs_q[SEL_WBASE];
  assign hbase_q = regs_q[SEL_HBASE];

  // R2: a write to a real register lands on the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && sel_valid) |=> (io_rdata == io_rdata || 1'b1) &&
      (regs_q[$past(io_sel) < SEL_W'(NUM_REGS) ? $past(io_sel) : 0] == $past(io_wdata)));

  // R2: without a write, the registers hold their values
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(bound_q) && $stable(wbase_q) && $stable(hbase_q));

  // R9: a write to the unused code touches nothing
  p_unused_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    write_lost |=> $stable(bound_q) && $stable(wbase_q) && $stable(hbase_q));

  // R9: a read of the unused code returns zero
  p_unused_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> io_rdata == '0);

  initial begin
    if (SEL_SPAN < NUM_REGS) $error("select too narrow");
  end

endmodule

// File: rtl/xlate_area_sel.sv
module xlate_area_sel
  import xlate_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] win_start,
  input  logic [PAGE_W-1:0] high_start,
  output area_e             area
);

  logic hit_high;
  logic hit_win;
  logic low_empty;
  logic win_empty;

  function automatic area_e classify(input logic [PAGE_W-1:0] pg,
                                     input logic [PAGE_W-1:0] ws,
                                     input logic [PAGE_W-1:0] hs);
    if (pg >= hs) return AREA_HIGH;
    if (pg >= ws) return AREA_WIN;
    return AREA_LOW;
  endfunction

  assign hit_high  = (page >= high_start);
  assign hit_win   = (page >= win_start);
  assign low_empty = (win_start == '0);
  assign win_empty = (high_start <= win_start);
  assign area      = classify(page, win_start, high_start);

  // R3: region codes follow the priority order of the boundaries
  p_high_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_high |-> area == AREA_HIGH);
  p_win_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_high && hit_win) |-> area == AREA_WIN);
  p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    area != 2'd3);

  // R8: empty regions are never selected
  p_low_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    low_empty |-> area != AREA_LOW);
  p_win_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_empty |-> area != AREA_WIN);

endmodule

// File: rtl/xlate_reloc.sv
module xlate_reloc #(
  parameter int PAGE_W = 4,
  parameter int BASE_W = 8
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [BASE_W-1:0] base,
  output logic [BASE_W-1:0] phys_hi
);

  function automatic logic [BASE_W-1:0] add_wrap(input logic [PAGE_W-1:0] pg,
                                                 input logic [BASE_W-1:0] b);
    logic [BASE_W:0] full;
    full = {1'b0, BASE_W'(pg)} + {1'b0, b};
    return full[BASE_W-1:0];
  endfunction

  assign phys_hi = add_wrap(page, base);

endmodule

// File: rtl/bank_xlate_top.sv
module bank_xlate_top
  import xlate_pkg::*;
#(
  parameter int         LOG_W     = 16,
  parameter int         PAGE_W    = 4,
  parameter int         BASE_W    = 8,
  parameter logic [7:0] BOUND_RST = 8'hF0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                io_sel,
  input  logic                      io_wr,
  input  logic [7:0]                io_wdata,
  output logic [7:0]                io_rdata,
  input  logic [15:0]               log_addr,
  output logic [19:0]               phys_addr,
  output logic [1:0]                area
);

  localparam int OFS_W  = LOG_W - PAGE_W;
  localparam int PHYS_W = OFS_W + BASE_W;

  logic [BASE_W-1:0] bound_q, wbase_q, hbase_q;
  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] win_start, high_start;
  logic [BASE_W-1:0] sel_base;
  logic [BASE_W-1:0] phys_hi;
  logic [OFS_W-1:0]  offset;
  area_e             area_s;

  xlate_regs #(.DATA_W(BASE_W), .BOUND_RST(BOUND_RST)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_sel   (io_sel),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .bound_q  (bound_q),
    .wbase_q  (wbase_q),
    .hbase_q  (hbase_q)
  );

  assign page       = log_addr[LOG_W-1:OFS_W];
  assign offset     = log_addr[OFS_W-1:0];
  assign win_start  = bound_q[PAGE_W-1:0];
  assign high_start = bound_q[2*PAGE_W-1:PAGE_W];

  xlate_area_sel #(.PAGE_W(PAGE_W)) u_area (
    .clk        (clk),
    .rst_n      (rst_n),
    .page       (page),
    .win_start  (win_start),
    .high_start (high_start),
    .area       (area_s)
  );

  always_comb begin
    unique case (area_s)
      AREA_WIN:  sel_base = wbase_q;
      AREA_HIGH: sel_base = hbase_q;
      default:   sel_base = '0;
    endcase
  end

  xlate_reloc #(.PAGE_W(PAGE_W), .BASE_W(BASE_W)) u_reloc (
    .page    (page),
    .base    (sel_base),
    .phys_hi (phys_hi)
  );

  assign phys_addr = {phys_hi, offset};
  assign area      = area_s;

  // R7: the page offset bypasses translation
  p_offset_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFS_W-1:0] == log_addr[OFS_W-1:0]);

  // R4: the low region is an identity map
  p_low_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    area == AREA_LOW |-> phys_addr == PHYS_W'(log_addr));

  // R5 / R10: the window page follows the window base, modulo 256
  p_win_reloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    area == AREA_WIN |->
      phys_addr[PHYS_W-1:OFS_W] == BASE_W'(wbase_q + BASE_W'(log_addr[LOG_W-1:OFS_W])));

  // R6: the high page follows the high base
  p_high_reloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    area == AREA_HIGH |->
      phys_addr[PHYS_W-1:OFS_W] == BASE_W'(hbase_q + BASE_W'(log_addr[LOG_W-1:OFS_W])));

endmodule

// File: tb/sim_bank_xlate_top.sv
module sim_bank_xlate_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  io_sel = '0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [15:0] log_addr = '0;
  logic [19:0] phys_addr;
  logic [1:0]  area;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  int m_reg [4];

  always #2 clk = ~clk;

  bank_xlate_top u0 (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .log_addr(log_addr),
    .phys_addr(phys_addr), .area(area)
  );

  function automatic int ref_area(int a);
    int pg = a / 4096;
    int ws = m_reg[0] % 16;
    int hs = m_reg[0] / 16;
    if (pg >= hs) return 2;
    if (pg >= ws) return 1;
    return 0;
  endfunction

  function automatic int ref_phys(int a);
    int r = ref_area(a);
    int b = (r == 0) ? 0 : (r == 1 ? m_reg[1] : m_reg[2]);
    return (((a / 4096) + b) % 256) * 4096 + (a % 4096);
  endfunction

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int sel, bit wr, int wd, int a, string rtag);
    int ra;
    string atag;
    @(negedge clk);
    io_sel = 2'(sel); io_wr = wr; io_wdata = 8'(wd); log_addr = 16'(a);
    #1;
    ra = ref_area(a);
    atag = (ra == 0) ? "R4" : (ra == 1 ? "R5" : "R6");
    cmp({rtag, " rdata"}, int'(io_rdata), (sel < 3) ? m_reg[sel] : 0);
    cmp("R3 area", int'(area), ra);
    cmp({atag, " phys"}, int'(phys_addr), ref_phys(a));
    cmp("R7 offset", int'(phys_addr[11:0]), a % 4096);
    @(posedge clk);
    if (wr && sel < 3) m_reg[sel] = wd;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_reg[0] = 'hF0; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset contents and identity map
    step(0, 0, 0, 'h1000, "R1");
    cmp("R1 phys 1000", int'(phys_addr), 'h01000);
    step(1, 0, 0, 'hF800, "R1");
    cmp("R1 phys F800", int'(phys_addr), 'h0F800);
    step(2, 0, 0, 'h0000, "R1");

    // R2: write visible after edge, not before
    step(0, 1, 'hC4, 'h4000, "R2");
    step(0, 0, 0, 'h4000, "R2");
    cmp("R8 win start", int'(area), 1);
    step(0, 0, 0, 'hBFFF, "R8");
    cmp("R8 win end", int'(area), 1);
    step(0, 0, 0, 'hC000, "R8");
    cmp("R8 high start", int'(area), 2);
    step(0, 0, 0, 'h3FFF, "R8");
    cmp("R8 low end", int'(area), 0);

    // R10 / R5: window base examples and wrap
    step(1, 1, 'h0A, 'h4000, "R2");
    step(1, 0, 0, 'h4000, "R5");
    cmp("R10 base 0A", int'(phys_addr), 'h0E000);
    step(1, 1, 'h08, 'h4000, "R2");
    step(1, 0, 0, 'h4000, "R5");
    cmp("R10 base 08", int'(phys_addr), 'h0C000);
    step(1, 1, 'hFF, 'h4123, "R2");
    step(1, 0, 0, 'h4123, "R10");
    cmp("R10 wrap", int'(phys_addr), 'h03123);

    // R6: high base
    step(2, 1, 'h40, 'hC000, "R2");
    step(2, 0, 0, 'hC010, "R6");
    cmp("R6 high base", int'(phys_addr), 'h4C010);

    // R9: unused select
    step(3, 1, 'h5A, 'h8000, "R9");
    step(3, 0, 0, 'h8000, "R9");
    step(0, 0, 0, 'h8000, "R9");
    step(1, 0, 0, 'h8000, "R9");
    step(2, 0, 0, 'h8000, "R9");

    // R8: empty regions
    step(0, 1, 'h33, 'h2FFF, "R2");
    step(0, 0, 0, 'h2FFF, "R8");
    cmp("R8 no window low", int'(area), 0);
    step(0, 0, 0, 'h3000, "R8");
    cmp("R8 no window high", int'(area), 2);
    step(0, 1, 'h00, 'h0000, "R2");
    step(0, 0, 0, 'h0000, "R8");
    cmp("R8 all high", int'(area), 2);

    // random sweep
    for (int i = 0; i < 4000; i++) begin
      int s = $urandom % 4;
      bit w = ($urandom % 3) == 0;
      step(s, w, $urandom % 256, $urandom % 65536, "R2");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule